// File: doc/BRIEF.md
# DRAM Refresh Command Decoder

This block sits behind the request decoder of a DRAM device and handles the refresh subset of row packets. Each cycle it may accept one packet: a valid strobe, a 3-bit row-operation code and an 8-bit argument field. Refresh commands come out as single-cycle precharge or activate strobes with a bank number, and activates also carry the row taken from an internal 12-bit refresh row register. Software-style load commands fill that register in two pieces: the low byte, and the upper four bits.

Every refresh command can be held back by up to three cycles. The two top bits of the argument field set the hold time. The held commands wait in a short slot pipeline, so a new packet can be accepted on every cycle. If two commands would fire in the same cycle, the older one keeps its slot, the newer one is dropped, and an error pulse is raised. An incrementing activate bumps the row register once its strobe has been issued. A load that lands on the same edge is merged in first, and the increment is then applied to the loaded value.

Top module: `refresh_cmd_decoder`

## Requirements
- R1: Op codes 001 (refresh precharge), 010 (refresh activate) and 011 (refresh activate with increment) each produce exactly one strobe. Op codes 000 and 111 produce no strobe and change no state. A precharge strobe and an activate strobe are never high in the same cycle.
- R2: The bank reported with a precharge or activate strobe is bits [2:0] of the argument field of the command that caused it.
- R3: A refresh command sampled at clock edge k with delay d = 2*arg[7] + arg[6] raises its strobe in the cycle that follows edge k+d. No strobe appears later than that.
- R4: An activate strobe carries the value the refresh row register holds in the cycle the strobe is high. The row output reads zero when no activate strobe is present.
- R5: After an incrementing activate strobe, the row register advances by one at the next edge. It wraps from 0xFFF to 0x000.
- R6: Op code 100 writes arg[7:0] into row bits [7:0] and keeps bits [11:8]. Op code 101 writes arg[3:0] into row bits [11:8] and keeps bits [7:0]. The register changes only through these loads or an increment.
- R7: Op code 110 is accepted but leaves the row register and the strobes untouched.
- R8: Commands arriving on consecutive cycles are all accepted and fire in delay order. A later command with a shorter delay may fire before an earlier one.
- R9: When a new command would fire in the same cycle as one already waiting, the waiting command fires, the new one is discarded, and the collision output is high for one cycle, starting the cycle after the new packet is sampled.
- R10: A row load sampled on the same edge as a pending increment takes effect first, and the increment is applied to the loaded value.
- R11: A synchronous active-low reset clears the row register to zero, drops all waiting commands and holds all strobes and the collision output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| pktValid | input | 1 | A row-packet request is present this cycle |
| opCode | input | 3 | Row-operation code of the packet |
| raField | input | 8 | Argument field: delay in [7:6], bank in [2:0], load data |
| prePulse | output | 1 | Refresh precharge strobe |
| preBank | output | 3 | Bank for the precharge strobe (zero when idle) |
| actPulse | output | 1 | Refresh activate strobe |
| actBank | output | 3 | Bank for the activate strobe (zero when idle) |
| actRow | output | 12 | Row for the activate strobe (zero when idle) |
| collisionErr | output | 1 | A newly issued command was dropped because of a firing-slot clash |

## Verification
The checker watches properties that hold on every cycle. It checks that precharge and activate strobes never overlap and that no strobe appears more than three cycles after the last refresh command. It checks that the row register moves only on a load or an increment, that a lone increment adds exactly one, that the unused high-load code leaves the row alone, and that a collision pulse always follows a packet. The exact firing cycle for each delay value, the bank and row values carried on the strobes, which of two clashing commands survives, and the merge of a load with a simultaneous increment can only be shown by the bench's directed scenarios, which compare the ports against values worked out from the requirements.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  localparam int ROW_W  = 12;
  localparam int RA_W   = 8;
  localparam int BANK_W = 3;
  localparam int OP_W   = 3;
  localparam int DLY_W  = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 3'b000,
    OP_RPRE    = 3'b001,
    OP_RACT    = 3'b010,
    OP_RACTINC = 3'b011,
    OP_LDLOW   = 3'b100,
    OP_LDMID   = 3'b101,
    OP_LDHIGH  = 3'b110,
    OP_RSVD    = 3'b111
  } rowOp_e;

  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_PRE    = 2'd1,
    K_ACT    = 2'd2,
    K_ACTINC = 2'd3
  } pendKind_e;

  typedef struct packed {
    pendKind_e         kind;
    logic [BANK_W-1:0] bank;
  } pendSlot_t;

  // strobes from control to the row datapath
  typedef struct packed {
    logic            loadLow;
    logic            loadMid;
    logic            incr;
    logic [RA_W-1:0] data;
  } rowStrb_t;
endpackage

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int DLYW = DLY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [RA_W-1:0]   raField,
  output rowStrb_t          rowStrb,
  output logic              preFire,
  output logic              actFire,
  output logic [BANK_W-1:0] fireBank,
  output logic              collisionErr
);
  localparam int DEPTH = 1 << DLYW;

  pendSlot_t         pend    [DEPTH];
  pendSlot_t         shifted [DEPTH];
  pendSlot_t         newSlot;
  rowOp_e            op;
  logic              isRefresh;
  logic              clash;
  logic [DLYW-1:0]   dly;

  // slot i holds the command that fires i cycles from now
  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    if (g < DEPTH - 1) begin : g_mid
      assign shifted[g] = pend[g+1];
    end else begin : g_top
      assign shifted[g] = '0;
    end
  end

  always_comb begin
    op           = rowOp_e'(opCode);
    dly          = raField[RA_W-1 -: DLYW];
    newSlot.bank = raField[BANK_W-1:0];
    newSlot.kind = K_NONE;
    if (pktValid) begin
      case (op)
        OP_RPRE:    newSlot.kind = K_PRE;
        OP_RACT:    newSlot.kind = K_ACT;
        OP_RACTINC: newSlot.kind = K_ACTINC;
        default:    newSlot.kind = K_NONE;
      endcase
    end
    isRefresh = (newSlot.kind != K_NONE);
    clash     = isRefresh && (shifted[dly].kind != K_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) pend[i] <= '0;
      collisionErr <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) pend[i] <= shifted[i];
      if (isRefresh && !clash) pend[dly] <= newSlot;
      collisionErr <= clash;
    end
  end

  always_comb begin
    preFire         = (pend[0].kind == K_PRE);
    actFire         = (pend[0].kind == K_ACT) || (pend[0].kind == K_ACTINC);
    fireBank        = pend[0].bank;
    rowStrb.loadLow = pktValid && (op == OP_LDLOW);
    rowStrb.loadMid = pktValid && (op == OP_LDMID);
    rowStrb.incr    = (pend[0].kind == K_ACTINC);
    rowStrb.data    = raField;
  end
endmodule

// File: rtl/refresh_row_dp.sv
module refresh_row_dp
  import refresh_pkg::*;
#(
  parameter int RW = ROW_W,
  parameter int AW = RA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  rowStrb_t      strb,
  output logic [RW-1:0] rowQ
);
  localparam int LOW_W = AW;
  localparam int MID_W = RW - AW;

  logic [RW-1:0] merged;
  logic [RW-1:0] nextRow;

  // loads merge first, the increment then acts on the merged value
  always_comb begin
    merged = rowQ;
    if (strb.loadLow) merged[LOW_W-1:0]  = strb.data[LOW_W-1:0];
    if (strb.loadMid) merged[RW-1:LOW_W] = strb.data[MID_W-1:0];
    nextRow = strb.incr ? merged + RW'(1) : merged;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rowQ <= '0;
    else       rowQ <= nextRow;
  end
endmodule

// File: rtl/refresh_cmd_decoder.sv
module refresh_cmd_decoder
  import refresh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pktValid,
  input  logic [2:0]  opCode,
  input  logic [7:0]  raField,
  output logic        prePulse,
  output logic [2:0]  preBank,
  output logic        actPulse,
  output logic [2:0]  actBank,
  output logic [11:0] actRow,
  output logic        collisionErr
);
  rowStrb_t          rowStrb;
  logic              preFire;
  logic              actFire;
  logic [BANK_W-1:0] fireBank;
  logic [ROW_W-1:0]  rowQ;

  refresh_ctrl #(.DLYW(DLY_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .pktValid     (pktValid),
    .opCode       (opCode),
    .raField      (raField),
    .rowStrb      (rowStrb),
    .preFire      (preFire),
    .actFire      (actFire),
    .fireBank     (fireBank),
    .collisionErr (collisionErr)
  );

  refresh_row_dp #(.RW(ROW_W), .AW(RA_W)) u_row (
    .clk  (clk),
    .rstN (rstN),
    .strb (rowStrb),
    .rowQ (rowQ)
  );

  assign prePulse = preFire;
  assign actPulse = actFire;
  assign preBank  = preFire ? fireBank : '0;
  assign actBank  = actFire ? fireBank : '0;
  assign actRow   = actFire ? rowQ : '0;
endmodule

// File: rtl/refresh_cmd_checker.sv
module refresh_cmd_checker
  import refresh_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             pktValid,
  input logic [2:0]       opCode,
  input logic             prePulse,
  input logic             actPulse,
  input logic             collisionErr,
  input logic [ROW_W-1:0] rowQ,
  input rowStrb_t         rowStrb
);
  logic [2:0] quietCnt;
  logic       refreshIn;

  assign refreshIn = pktValid && (opCode == 3'b001 || opCode == 3'b010 || opCode == 3'b011);

  always_ff @(posedge clk) begin
    if (!rstN)             quietCnt <= 3'd7;
    else if (refreshIn)    quietCnt <= 3'd0;
    else if (quietCnt != 3'd7) quietCnt <= quietCnt + 3'd1;
  end

  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(prePulse && actPulse));

  a_r3_no_late_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt >= 3'd4) |-> (!prePulse && !actPulse));

  a_r9_clash_needs_packet: assert property (@(posedge clk) disable iff (!rstN)
    collisionErr |-> $past(pktValid));

  a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    $past(rowStrb.incr && !rowStrb.loadLow && !rowStrb.loadMid) |-> (rowQ == $past(rowQ) + 12'd1));

  a_r6_row_moves_only_on_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (rowQ != $past(rowQ)) |-> $past(rowStrb.loadLow || rowStrb.loadMid || rowStrb.incr));

  a_r7_high_load_inert: assert property (@(posedge clk) disable iff (!rstN)
    $past(pktValid && opCode == 3'b110 && !rowStrb.incr) |-> (rowQ == $past(rowQ)));
endmodule

bind refresh_cmd_decoder refresh_cmd_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .pktValid     (pktValid),
  .opCode       (opCode),
  .prePulse     (prePulse),
  .actPulse     (actPulse),
  .collisionErr (collisionErr),
  .rowQ         (rowQ),
  .rowStrb      (rowStrb)
);

// File: tb/refresh_cmd_decoder_bench.sv
module refresh_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        pktValid;
  logic [2:0]  opCode;
  logic [7:0]  raField;
  logic        prePulse;
  logic [2:0]  preBank;
  logic        actPulse;
  logic [2:0]  actBank;
  logic [11:0] actRow;
  logic        collisionErr;
  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  refresh_cmd_decoder u_refresh_cmd_decoder (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .opCode(opCode), .raField(raField),
    .prePulse(prePulse), .preBank(preBank), .actPulse(actPulse), .actBank(actBank),
    .actRow(actRow), .collisionErr(collisionErr)
  );

  task automatic checkVal(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] arg(input int d, input int bank);
    return {2'(d), 3'b000, 3'(bank)};
  endfunction

  // drive one cycle of input, return at the next falling edge
  task automatic step(input logic v, input logic [2:0] op, input logic [7:0] ra);
    pktValid = v; opCode = op; raField = ra;
    @(negedge clk);
    pktValid = 1'b0; opCode = 3'b000; raField = 8'h00;
  endtask

  task automatic idle();
    step(1'b0, 3'b000, 8'h00);
  endtask

  task automatic setRow(input logic [11:0] v);
    step(1'b1, 3'b100, v[7:0]);
    step(1'b1, 3'b101, {4'h0, v[11:8]});
  endtask

  task automatic testReset();
    checkVal("R11 pre idle after reset", prePulse, 0);
    checkVal("R11 act idle after reset", actPulse, 0);
    checkVal("R11 collision low after reset", collisionErr, 0);
    step(1'b1, 3'b010, arg(0, 5));
    checkVal("R1 activate strobe", actPulse, 1);
    checkVal("R2 activate bank", actBank, 5);
    checkVal("R11 row cleared", actRow, 12'h000);
  endtask

  task automatic testLoads();
    step(1'b1, 3'b100, 8'hA5);
    step(1'b1, 3'b101, 8'hF3);
    step(1'b1, 3'b010, arg(0, 1));
    checkVal("R6 low+mid load", actRow, 12'h3A5);
    checkVal("R4 act row shown", actPulse, 1);
    step(1'b1, 3'b100, 8'h0C);
    step(1'b1, 3'b010, arg(0, 1));
    checkVal("R6 low load keeps upper", actRow, 12'h30C);
  endtask

  task automatic testDelays();
    for (int d = 0; d < 4; d++) begin
      int hit = -1;
      int bank = 0;
      step(1'b1, 3'b001, arg(d, d + 2));
      for (int c = 0; c < 5; c++) begin
        if (prePulse && hit < 0) begin hit = c; bank = preBank; end
        idle();
      end
      checkVal($sformatf("R3 delay %0d firing cycle", d), hit, d);
      checkVal($sformatf("R2 precharge bank delay %0d", d), bank, d + 2);
    end
  endtask

  task automatic testIncWrap();
    setRow(12'hFFF);
    step(1'b1, 3'b011, arg(0, 7));
    checkVal("R5 inc act shows row", actRow, 12'hFFF);
    checkVal("R2 inc act bank", actBank, 7);
    step(1'b1, 3'b010, arg(0, 0));
    checkVal("R5 wrap to zero", actRow, 12'h000);
  endtask

  task automatic testIgnored();
    setRow(12'h123);
    step(1'b1, 3'b000, 8'hFF);
    checkVal("R1 nop no strobe", prePulse | actPulse, 0);
    step(1'b1, 3'b111, 8'hFF);
    checkVal("R1 reserved no strobe", prePulse | actPulse, 0);
    step(1'b1, 3'b110, 8'hFF);
    checkVal("R7 high load no strobe", prePulse | actPulse, 0);
    step(1'b1, 3'b010, arg(0, 0));
    checkVal("R7 row unchanged by ignored codes", actRow, 12'h123);
  endtask

  task automatic testBackToBack();
    step(1'b1, 3'b001, arg(0, 1));
    checkVal("R8 first pre", preBank, 1);
    step(1'b1, 3'b010, arg(0, 2));
    checkVal("R8 second act", actBank, 2);
    checkVal("R8 no pre with act", prePulse, 0);
    step(1'b1, 3'b001, arg(0, 3));
    checkVal("R8 third pre", preBank, 3);
    step(1'b1, 3'b010, arg(3, 4));
    step(1'b1, 3'b001, arg(0, 6));
    checkVal("R8 later short cmd fires first", preBank, 6);
    checkVal("R8 no collision on reorder", collisionErr, 0);
    idle();
    idle();
    checkVal("R8 long delayed act fires", actBank, 4);
    idle();
  endtask

  task automatic testCollision();
    step(1'b1, 3'b010, arg(2, 4));
    step(1'b1, 3'b001, arg(1, 6));
    checkVal("R9 collision flagged", collisionErr, 1);
    idle();
    checkVal("R9 older act wins", actBank, 4);
    checkVal("R9 newer pre dropped", prePulse, 0);
    checkVal("R9 collision one cycle", collisionErr, 0);
    idle();
    checkVal("R9 dropped pre never fires", prePulse, 0);
    idle();
  endtask

  task automatic testLoadMerge();
    setRow(12'h010);
    step(1'b1, 3'b011, arg(1, 0));
    step(1'b1, 3'b100, 8'h40);
    checkVal("R10 load before pending inc shows", actRow, 12'h040);
    step(1'b1, 3'b010, arg(0, 0));
    checkVal("R10 inc applied to loaded row", actRow, 12'h041);
    setRow(12'h200);
    step(1'b1, 3'b011, arg(0, 0));
    checkVal("R4 inc act row", actRow, 12'h200);
    step(1'b1, 3'b101, 8'h05);
    step(1'b1, 3'b010, arg(0, 0));
    checkVal("R10 same-edge load then inc", actRow, 12'h501);
  endtask

  task automatic testResetFlight();
    int seen = 0;
    setRow(12'h0AB);
    step(1'b1, 3'b001, arg(3, 1));
    rstN = 1'b0;
    idle();
    idle();
    rstN = 1'b1;
    for (int c = 0; c < 5; c++) begin
      seen = seen | prePulse | actPulse;
      idle();
    end
    checkVal("R11 pending dropped by reset", seen, 0);
    step(1'b1, 3'b010, arg(0, 0));
    checkVal("R11 row zero after reset", actRow, 12'h000);
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; pktValid = 1'b0; opCode = 3'b000; raField = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLoads();
    testDelays();
    testIncWrap();
    testIgnored();
    testBackToBack();
    testCollision();
    testLoadMerge();
    testResetFlight();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule